// File: doc/BRIEF.md
# Management-Port PHY Register Responder

This block answers register accesses that arrive on a PHY management request port. Each request names a PHY address, a register number, a direction and, for writes, 16 bits of data. The block holds a 32-entry, 16-bit register file and behaves as one PHY at a configured address. Most registers read back what was written, but the basic status, link-partner ability, speed and diagnostic registers are produced on the fly from the stored advertisement word and a link-up input.

Requests use a valid/ready handshake: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only reads produce a response. The response channel also uses valid/ready: `rsp_valid` stays high with unchanged `rsp_data` until `rsp_ready` is seen high on a clock edge. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle, so a stalled consumer stalls new requests. Writes flow through the same request channel and are subject to the same back-pressure.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 (advertisement) reads 0x01E1, and other plain registers read 0x0000.
- R2: A read of register 1 returns 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) while `link_up` is high and 0x0000 while it is low.
- R3: A read of register 5 returns 0x4001 OR (register 4 AND 0x01E0), whatever the link state.
- R4: A read of register 17 always returns 0x8000.
- R5: A read of register 18 with `link_up` high returns bit 10 = register 4 bit 7 OR bit 8, bit 11 = register 4 bit 8 OR bit 6, all other bits 0; with `link_up` low it returns 0x0000.
- R6: A write to the configured PHY address stores all 16 data bits in the named register; registers other than 1, 5, 17 and 18 read the stored value back. Writes to 1, 5, 17 and 18 are stored but do not change what those reads return.
- R7: A read to any PHY address other than `cfg_phy_addr` returns 0xFFFF; a write to such an address changes no register.
- R8: A read taken on clock edge N presents `rsp_valid` high with its data after edge N; a write produces no response.
- R9: While `rsp_valid` is high and `rsp_ready` low, `rsp_valid` stays high, `rsp_data` stays unchanged and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_phy_addr | input | 5 | PHY address this responder answers |
| link_up | input | 1 | Link state feeding the computed status |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | 16 | Read response data |

## Verification
A read's data is due exactly one edge after the edge that takes it, so the driver checks `rsp_valid` two nanoseconds after that edge, and the scoreboard monitor compares data just before each edge where `rsp_valid` and `rsp_ready` are both high, which is the edge the response is consumed. Writes are checked indirectly by a later read, and by confirming no response appears after them. Back-pressure is checked by holding `rsp_ready` low for several cycles and sampling the held response and `req_ready` mid-cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DATA_W = 16;
  localparam int REG_W  = 5;
  localparam int NREGS  = 1 << REG_W;

  typedef logic [REG_W-1:0]  reg_idx_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam reg_idx_t IDX_CTRL    = 5'd0;
  localparam reg_idx_t IDX_STAT    = 5'd1;
  localparam reg_idx_t IDX_ID_HI   = 5'd2;
  localparam reg_idx_t IDX_ID_LO   = 5'd3;
  localparam reg_idx_t IDX_ADV     = 5'd4;
  localparam reg_idx_t IDX_PARTNER = 5'd5;
  localparam reg_idx_t IDX_SPEED   = 5'd17;
  localparam reg_idx_t IDX_DIAG    = 5'd18;

  // Advertisement mode field sits at bits 8:5 of the advertisement word
  localparam int MODE_LO = 5;
  localparam int MODE_HI = 8;
  localparam int MODE_W  = MODE_HI - MODE_LO + 1;

  localparam word_t STAT_LINK_UP = 16'h782E;
  localparam word_t PARTNER_BASE = 16'h4001;
  localparam word_t SPEED_WORD   = 16'h8000;
  localparam int    DIAG_SPD_BIT = 10;
  localparam int    DIAG_DPX_BIT = 11;

  function automatic word_t reset_word(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_idx_t          wr_idx,
  input  word_t             wr_data,
  input  reg_idx_t          rd_idx,
  output word_t             rd_word,
  output logic [MODE_W-1:0] adv_modes
);
  logic [NREGS-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < NREGS; i++) begin : g_entry
    word_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= reset_word(i);
      end else if (wr_en && (wr_idx == reg_idx_t'(i))) begin
        q <= wr_data;
      end
    end
    assign bank[i] = q;
  end

  assign rd_word   = bank[rd_idx];
  assign adv_modes = bank[IDX_ADV][MODE_HI:MODE_LO];

  // R7
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(adv_modes));

  // R6
  adv_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_ADV) |=> adv_modes == $past(wr_data[MODE_HI:MODE_LO]));
endmodule

// File: rtl/phy_status_view.sv
module phy_status_view
  import phy_mgmt_pkg::*;
(
  input  reg_idx_t          sel,
  input  word_t             stored,
  input  logic [MODE_W-1:0] adv_modes,
  input  logic              link_up,
  output word_t             view
);
  // adv_modes: [0]=10 half, [1]=10 full, [2]=100 half, [3]=100 full
  logic any_100;
  logic any_full;
  word_t diag;

  assign any_100  = adv_modes[2] | adv_modes[3];
  assign any_full = adv_modes[3] | adv_modes[1];

  always_comb begin
    diag = '0;
    diag[DIAG_SPD_BIT] = any_100;
    diag[DIAG_DPX_BIT] = any_full;
  end

  always_comb begin
    case (sel)
      IDX_STAT:    view = link_up ? STAT_LINK_UP : '0;
      IDX_PARTNER: view = PARTNER_BASE | (word_t'(adv_modes) << MODE_LO);
      IDX_SPEED:   view = SPEED_WORD;
      IDX_DIAG:    view = link_up ? diag : '0;
      default:     view = stored;
    endcase
  end
endmodule

// File: rtl/phy_rsp_slot.sv
module phy_rsp_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              slot_free,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rsp_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_W-1:0]  cfg_phy_addr,
  input  logic              link_up,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic              take;
  logic              hit;
  logic              wr_en;
  logic              rd_take;
  word_t             stored;
  word_t             view;
  word_t             rd_val;
  logic [MODE_W-1:0] modes;

  assign take    = req_valid && req_ready;
  assign hit     = (req_phy == cfg_phy_addr);
  assign wr_en   = take && req_write && hit;
  assign rd_take = take && !req_write;
  assign rd_val  = hit ? view : '1;

  phy_reg_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (req_reg),
    .wr_data  (req_wdata),
    .rd_idx   (req_reg),
    .rd_word  (stored),
    .adv_modes(modes)
  );

  phy_status_view u_view (
    .sel      (req_reg),
    .stored   (stored),
    .adv_modes(modes),
    .link_up  (link_up),
    .view     (view)
  );

  phy_rsp_slot #(.DATA_W(DATA_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_take),
    .load_data(rd_val),
    .slot_free(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data)
  );

  // R4
  speed_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && hit && req_reg == IDX_SPEED) |=> rsp_data == SPEED_WORD);

  // R2
  stat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && hit && req_reg == IDX_STAT && !link_up) |=> rsp_data == '0);

  // R7
  absent_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !hit) |=> rsp_data == '1);

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/sim_phy_mgmt_responder.sv
module sim_phy_mgmt_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_phy_addr = 5'd7;
  logic        link_up = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;

  int total = 0;
  int bad = 0;
  logic [15:0] model [32];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  phy_mgmt_responder u0 (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_rd(input logic [4:0] phy, input logic [4:0] r);
    logic [15:0] a;
    logic [15:0] v;
    a = model[4];
    if (phy != cfg_phy_addr) return 16'hFFFF;
    case (r)
      5'd1:  v = link_up ? 16'h782E : 16'h0000;
      5'd5:  v = 16'h4001 | (a & 16'h01E0);
      5'd17: v = 16'h8000;
      5'd18: begin
        v = '0;
        if (link_up) begin
          v[10] = a[7] | a[8];
          v[11] = a[8] | a[6];
        end
      end
      default: v = model[r];
    endcase
    return v;
  endfunction

  task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] r,
                       input logic [15:0] d, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = r; req_wdata = d;
    if (!wr) begin
      exp_q.push_back(expect_rd(phy, r));
      tag_q.push_back(tag);
    end else if (phy == cfg_phy_addr) begin
      model[r] = d;
    end
    @(posedge clk);
    #2;
    // R8: response due right after the taking edge, none for writes
    check(wr ? "R8 no write response" : "R8 response timing", {15'b0, rsp_valid}, wr ? 16'd0 : 16'd1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] phy, input logic [4:0] r, input string tag);
    issue(1'b0, phy, r, '0, tag);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    issue(1'b1, phy, r, d, "write");
  endtask

  // Scoreboard monitor: samples just before the edge that completes a handshake
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("unexpected response", rsp_data, 16'hxxxx);
        end else begin
          check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    for (int i = 0; i < 32; i++) model[i] = '0;
    model[0] = 16'h3100; model[2] = 16'h0300; model[3] = 16'hE400; model[4] = 16'h01E1;
    repeat (3) @(negedge clk);
    check("R8 reset rsp_valid", {15'b0, rsp_valid}, 16'd0);
    rst_n = 1'b1;

    rd(5'd7, 5'd0, "R1 reg0");
    rd(5'd7, 5'd2, "R1 reg2");
    rd(5'd7, 5'd3, "R1 reg3");
    rd(5'd7, 5'd4, "R1 reg4");
    rd(5'd7, 5'd10, "R1 reg10");
    rd(5'd7, 5'd1, "R2 link up");
    rd(5'd7, 5'd5, "R3 reset adv");
    rd(5'd7, 5'd17, "R4 speed");
    rd(5'd7, 5'd18, "R5 reset adv");

    wr(5'd7, 5'd9, 16'h1234);
    rd(5'd7, 5'd9, "R6 plain store");
    wr(5'd7, 5'd5, 16'hABCD);
    wr(5'd7, 5'd17, 16'h0000);
    rd(5'd7, 5'd5, "R6 computed reg5 ignores write");
    rd(5'd7, 5'd17, "R4 after write");

    wr(5'd7, 5'd4, 16'h0041);
    rd(5'd7, 5'd5, "R3 10full adv");
    rd(5'd7, 5'd18, "R5 10full adv");
    wr(5'd7, 5'd4, 16'h0080);
    rd(5'd7, 5'd18, "R5 100half adv");
    rd(5'd7, 5'd4, "R6 adv stored");

    link_up = 1'b0;
    rd(5'd7, 5'd1, "R2 link down");
    rd(5'd7, 5'd18, "R5 link down");
    rd(5'd7, 5'd5, "R3 link down");
    rd(5'd7, 5'd17, "R4 link down");
    link_up = 1'b1;

    rd(5'd3, 5'd0, "R7 absent read");
    wr(5'd3, 5'd9, 16'h5555);
    rd(5'd7, 5'd9, "R7 absent write ignored");

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(5'd7, 5'd17, "R9 held response");
    #3 held = rsp_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R9 valid held", {15'b0, rsp_valid}, 16'd1);
      check("R9 data held", rsp_data, held);
      check("R9 req_ready low", {15'b0, req_ready}, 16'd0);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 drained", {15'b0, rsp_valid}, 16'd0);
    check("scoreboard empty", 16'(exp_q.size()), 16'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule